// File: doc/BRIEF.md
# Single-Pass UDP Datagram Streamer with Checksum Trailer

The block turns a stream of 16-bit microphone sample words into Ethernet/IPv4/UDP frames, one byte per clock, without ever holding a whole datagram in storage. The UDP checksum field in the header carries a fixed value chosen by configuration. The header can therefore leave the block before any payload word exists. The payload is closed by a two-byte trailer, computed from everything sent before it, that makes the datagram's ones'-complement checksum come out right for that fixed value.

Each datagram opens its UDP payload with a 32-bit packet index. The index counts frames from reset, so a receiver can spot lost packets from gaps in the count. Payload words are pulled over a valid/ready handshake only in the cycles where their high byte is due. A missing word after the frame has begun is replaced by a fill word and latched as an error. Before a frame begins, the block simply waits for data. Preamble, frame check sequence and PHY signalling belong to the MAC stage downstream.

Top module: `udp_fixup_streamer`

## Requirements
- R1: A frame for N payload words is exactly 48+2N contiguous bytes with out_valid high, out_sof on the first byte and out_eof on the last. The bytes are, in order and all big-endian:
  - destination MAC, source MAC, type 0x0800;
  - an IPv4 header of 0x45, 0x00, total length 34+2N, identification equal to the low 16 bits of the packet index, 0x4000, TTL 0x40, protocol 0x11, header checksum, source IP, destination IP;
  - a UDP header of source port, destination port, length 14+2N, checksum field;
  - the 4-byte index, the payload and a 2-byte trailer.
- R2: The IPv4 header checksum makes the ones'-complement sum of the ten header words equal 0xFFFF.
- R3: The UDP checksum field equals cfg_csum_const. The ones'-complement sum over the pseudo-header (source IP, destination IP, 0x0011, UDP length) and the whole UDP segment equals 0xFFFF.
- R4: The trailer is never 0x0000. When the required value is zero, 0xFFFF is sent instead.
- R5: The packet index is 0 for the first frame after reset and rises by one per frame.
- R6: Payload words appear in arrival order, high byte first. Each word is taken in a cycle where in_ready and in_valid are both high, and each of the N payload slots takes exactly one word.
- R7: While in_valid stays low and no frame is running, no frame starts, out_valid stays low and in_ready stays low.
- R8: If in_valid is low when a payload word is due inside a frame, the fill word 0x5A5A takes that slot. underrun goes high and stays high until reset, and the checksum of R3 still holds.
- R9: The configuration inputs are sampled when a frame starts. Changing them during the frame does not alter that frame's bytes.
- R10: Frames longer than 1500 bytes are produced; a 1200-word payload yields a 2448-byte frame.
- R11: After out_eof, out_valid stays low for at least 12 cycles before the next out_sof.
- R12: During and right after reset, out_valid, out_sof, out_eof, in_ready and underrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_csum_const | input | 16 | Fixed value placed in the UDP checksum field |
| cfg_pay_words | input | LEN_W | Payload words per frame (1 or more) |
| in_data | input | 16 | Payload sample word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | The block takes a word this cycle if in_valid |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | out_data holds a frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| underrun | output | 1 | Sticky: a payload slot was filled for lack of data |

## Verification
The hardest case to reach from the ports is a trailer whose required value is exactly zero. This happens only when every byte before it already sums to 0xFFFF. The bench works out the sum of the header fields, the index and all but the last payload word from its own model. It then picks the last word as the complement of that sum, which forces the 0x0000/0xFFFF choice on a known frame. A mid-frame underrun is also hard to reach. The bench reaches it by holding in_valid low on chosen payload slots after the header has left, and then checks the fill word, the sticky flag and the checksum together.

// File: rtl/udpx_pkg.sv
package udpx_pkg;

  localparam int ETH_BYTES = 14;
  localparam int IP_BYTES  = 20;
  localparam int UDP_BYTES = 8;
  localparam int IDX_BYTES = 4;
  localparam int PRE_BYTES = ETH_BYTES + IP_BYTES + UDP_BYTES + IDX_BYTES;
  localparam int PRE_BITS  = PRE_BYTES * 8;

  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
  localparam logic [15:0] IP_VER_TOS  = 16'h4500;
  localparam logic [15:0] IP_FLAGS    = 16'h4000;
  localparam logic [15:0] IP_TTL_PROT = 16'h4011;
  localparam logic [15:0] PROTO_UDP   = 16'h0011;
  localparam logic [15:0] UDP_FIXED   = 16'(UDP_BYTES + IDX_BYTES + 2);
  localparam logic [15:0] IP_FIXED    = 16'(IP_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } udpx_state_t;

  typedef struct packed {
    logic [47:0] dst_mac;
    logic [47:0] src_mac;
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [15:0] src_port;
    logic [15:0] dst_port;
    logic [15:0] csum_const;
  } udpx_cfg_t;

  // ones'-complement 16-bit addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/udpx_hdr_sums.sv
module udpx_hdr_sums
  import udpx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      src_ip,
  input  logic [31:0]      dst_ip,
  input  logic [15:0]      src_port,
  input  logic [15:0]      dst_port,
  input  logic [15:0]      csum_const,
  input  logic [LEN_W-1:0] pay_words,
  input  logic [31:0]      seq,
  output logic [15:0]      udp_len,
  output logic [15:0]      ip_len,
  output logic [15:0]      ip_csum_q,
  output logic [15:0]      seed_sum_q
);

  logic [15:0] ip_sum;
  logic [15:0] seed_sum;

  always_comb begin
    udp_len = 16'({pay_words, 1'b0}) + UDP_FIXED;
    ip_len  = udp_len + IP_FIXED;
  end

  // IPv4 header words, checksum slot counted as zero
  always_comb begin
    ip_sum = IP_VER_TOS;
    ip_sum = oc_add(ip_sum, ip_len);
    ip_sum = oc_add(ip_sum, seq[15:0]);
    ip_sum = oc_add(ip_sum, IP_FLAGS);
    ip_sum = oc_add(ip_sum, IP_TTL_PROT);
    ip_sum = oc_add(ip_sum, src_ip[31:16]);
    ip_sum = oc_add(ip_sum, src_ip[15:0]);
    ip_sum = oc_add(ip_sum, dst_ip[31:16]);
    ip_sum = oc_add(ip_sum, dst_ip[15:0]);
  end

  // pseudo-header, UDP header with the fixed field, packet index
  always_comb begin
    seed_sum = src_ip[31:16];
    seed_sum = oc_add(seed_sum, src_ip[15:0]);
    seed_sum = oc_add(seed_sum, dst_ip[31:16]);
    seed_sum = oc_add(seed_sum, dst_ip[15:0]);
    seed_sum = oc_add(seed_sum, PROTO_UDP);
    seed_sum = oc_add(seed_sum, udp_len);
    seed_sum = oc_add(seed_sum, src_port);
    seed_sum = oc_add(seed_sum, dst_port);
    seed_sum = oc_add(seed_sum, udp_len);
    seed_sum = oc_add(seed_sum, csum_const);
    seed_sum = oc_add(seed_sum, seq[31:16]);
    seed_sum = oc_add(seed_sum, seq[15:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_csum_q  <= '0;
      seed_sum_q <= '0;
    end else begin
      ip_csum_q  <= ~ip_sum;
      seed_sum_q <= seed_sum;
    end
  end

endmodule

// File: rtl/udpx_hdr_mux.sv
module udpx_hdr_mux
  import udpx_pkg::*;
(
  input  udpx_cfg_t   cfg,
  input  logic [31:0] seq,
  input  logic [15:0] ip_len,
  input  logic [15:0] udp_len,
  input  logic [15:0] ip_csum,
  input  logic [5:0]  sel,
  output logic [7:0]  byte_o
);

  logic [PRE_BITS-1:0] hdr;
  logic [5:0]          rev;

  always_comb begin
    hdr = {cfg.dst_mac, cfg.src_mac, ETYPE_IPV4,
           IP_VER_TOS, ip_len, seq[15:0], IP_FLAGS, IP_TTL_PROT, ip_csum,
           cfg.src_ip, cfg.dst_ip,
           cfg.src_port, cfg.dst_port, udp_len, cfg.csum_const,
           seq};
    rev    = 6'(PRE_BYTES - 1) - sel;
    byte_o = hdr[{rev, 3'b000} +: 8];
  end

endmodule

// File: rtl/udpx_csum_acc.sv
module udpx_csum_acc
  import udpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [15:0] load_val,
  input  logic        add,
  input  logic [15:0] add_val,
  output logic [15:0] trailer
);

  logic [15:0] sum_q;
  logic [15:0] need;

  always_ff @(posedge clk) begin
    if (rst)       sum_q <= '0;
    else if (load) sum_q <= load_val;
    else if (add)  sum_q <= oc_add(sum_q, add_val);
  end

  // word that brings the total to 0xFFFF; zero is sent as its other form
  always_comb begin
    need    = ~sum_q;
    trailer = (need == 16'h0000) ? 16'hFFFF : need;
  end

endmodule

// File: rtl/udp_fixup_streamer.sv
module udp_fixup_streamer
  import udpx_pkg::*;
#(
  parameter int          LEN_W      = 12,
  parameter int          IFG_CYCLES = 12,
  parameter logic [15:0] FILL_WORD  = 16'h5A5A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [47:0]      cfg_dst_mac,
  input  logic [47:0]      cfg_src_mac,
  input  logic [31:0]      cfg_src_ip,
  input  logic [31:0]      cfg_dst_ip,
  input  logic [15:0]      cfg_src_port,
  input  logic [15:0]      cfg_dst_port,
  input  logic [15:0]      cfg_csum_const,
  input  logic [LEN_W-1:0] cfg_pay_words,
  input  logic [15:0]      in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic             underrun
);

  localparam int POS_W = LEN_W + 2;
  localparam int GAP_W = $clog2(IFG_CYCLES + 1);
  localparam logic [POS_W-1:0] PAY_POS = POS_W'(PRE_BYTES);

  udpx_state_t      state_q;
  logic [POS_W-1:0] pos_q;
  logic [GAP_W-1:0] gap_q;
  udpx_cfg_t        cfg_q;
  logic [LEN_W-1:0] words_q;
  logic [31:0]      seq_q;
  logic [7:0]       lo_q;

  logic [POS_W-1:0] trl_pos;
  logic [POS_W-1:0] last_pos;
  logic             in_hdr;
  logic             in_pay;
  logic             hi_slot;
  logic [15:0]      word;
  logic [7:0]       hdr_byte;
  logic [7:0]       next_byte;
  logic [15:0]      udp_len;
  logic [15:0]      ip_len;
  logic [15:0]      ip_csum;
  logic [15:0]      seed_sum;
  logic [15:0]      trailer;
  logic             acc_load;

  always_comb begin
    trl_pos  = PAY_POS + POS_W'({words_q, 1'b0});
    last_pos = trl_pos + POS_W'(1);
    in_hdr   = (state_q == ST_RUN) && (pos_q < PAY_POS);
    in_pay   = (state_q == ST_RUN) && (pos_q >= PAY_POS) && (pos_q < trl_pos);
    hi_slot  = in_pay && !pos_q[0];
    word     = in_valid ? in_data : FILL_WORD;
    acc_load = (state_q == ST_RUN) && (pos_q == POS_W'(1));
  end

  assign in_ready = hi_slot;

  udpx_hdr_sums #(.LEN_W(LEN_W)) u_sums (
    .clk        (clk),
    .rst        (rst),
    .src_ip     (cfg_q.src_ip),
    .dst_ip     (cfg_q.dst_ip),
    .src_port   (cfg_q.src_port),
    .dst_port   (cfg_q.dst_port),
    .csum_const (cfg_q.csum_const),
    .pay_words  (words_q),
    .seq        (seq_q),
    .udp_len    (udp_len),
    .ip_len     (ip_len),
    .ip_csum_q  (ip_csum),
    .seed_sum_q (seed_sum)
  );

  udpx_hdr_mux u_mux (
    .cfg     (cfg_q),
    .seq     (seq_q),
    .ip_len  (ip_len),
    .udp_len (udp_len),
    .ip_csum (ip_csum),
    .sel     (pos_q[5:0]),
    .byte_o  (hdr_byte)
  );

  udpx_csum_acc u_acc (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_load),
    .load_val (seed_sum),
    .add      (hi_slot),
    .add_val  (word),
    .trailer  (trailer)
  );

  always_comb begin
    if (in_hdr)                next_byte = hdr_byte;
    else if (in_pay)           next_byte = pos_q[0] ? lo_q : word[15:8];
    else if (pos_q == trl_pos) next_byte = trailer[15:8];
    else                       next_byte = trailer[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pos_q     <= '0;
      gap_q     <= '0;
      cfg_q     <= '0;
      words_q   <= '0;
      seq_q     <= '0;
      lo_q      <= '0;
      underrun  <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (hi_slot) lo_q <= word[7:0];
      if (hi_slot && !in_valid) underrun <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          out_valid <= 1'b0;
          out_sof   <= 1'b0;
          out_eof   <= 1'b0;
          if (in_valid) begin
            state_q <= ST_RUN;
            pos_q   <= '0;
            words_q <= cfg_pay_words;
            cfg_q   <= '{dst_mac: cfg_dst_mac, src_mac: cfg_src_mac,
                         src_ip: cfg_src_ip, dst_ip: cfg_dst_ip,
                         src_port: cfg_src_port, dst_port: cfg_dst_port,
                         csum_const: cfg_csum_const};
          end
        end
        ST_RUN: begin
          out_data  <= next_byte;
          out_valid <= 1'b1;
          out_sof   <= (pos_q == '0);
          out_eof   <= (pos_q == last_pos);
          if (pos_q == last_pos) begin
            state_q <= ST_GAP;
            gap_q   <= '0;
            seq_q   <= seq_q + 32'd1;
          end else begin
            pos_q <= pos_q + POS_W'(1);
          end
        end
        default: begin
          out_valid <= 1'b0;
          out_sof   <= 1'b0;
          out_eof   <= 1'b0;
          gap_q     <= gap_q + GAP_W'(1);
          if (gap_q == GAP_W'(IFG_CYCLES - 1)) state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/udpx_chk.sv
module udpx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic underrun
);

  // R1
  marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eof) |-> out_valid);

  // R1
  frame_opens_sof_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sof);

  // R6
  take_emits_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> out_valid);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R8
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(in_ready && !in_valid));

  // R11
  gap_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |=> !out_valid);

endmodule

bind udp_fixup_streamer udpx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .underrun  (underrun)
);

// File: tb/udp_fixup_streamer_tb.sv
module udp_fixup_streamer_tb;

  localparam int LEN_W = 12;
  localparam logic [15:0] FILL = 16'h5A5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [47:0] cfg_dst_mac, cfg_src_mac;
  logic [31:0] cfg_src_ip, cfg_dst_ip;
  logic [15:0] cfg_src_port, cfg_dst_port, cfg_csum_const;
  logic [LEN_W-1:0] cfg_pay_words;
  logic [15:0] in_data;
  logic in_valid;
  logic in_ready;
  logic [7:0] out_data;
  logic out_valid, out_sof, out_eof, underrun;

  always #4 clk = ~clk;

  udp_fixup_streamer #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_dst_mac(cfg_dst_mac), .cfg_src_mac(cfg_src_mac),
    .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
    .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
    .cfg_csum_const(cfg_csum_const), .cfg_pay_words(cfg_pay_words),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .underrun(underrun)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_seq = 0;

  logic [7:0]  cap [0:4095];
  logic [7:0]  expb [0:4095];
  logic [15:0] pw [0:2047];
  logic [15:0] slot_w [0:2047];
  int cap_n, slot_n, ep, low_cnt;
  bit sof_ok, eof_ok, hung;

  logic [47:0] s_dmac, s_smac;
  logic [31:0] s_sip, s_dip;
  logic [15:0] s_sp, s_dp, s_k;

  function automatic logic [15:0] ocs(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [63:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      expb[ep] = v[i*8 +: 8];
      ep++;
    end
  endtask

  function automatic logic [15:0] cap16(input int at);
    return {cap[at], cap[at+1]};
  endfunction

  // bench model of one frame
  task automatic build_exp(input int n);
    logic [15:0] ulen, ilen, ics, s, t;
    ulen = 16'(14 + 2*n);
    ilen = 16'(34 + 2*n);
    ics = 16'h4500;
    ics = ocs(ics, ilen); ics = ocs(ics, exp_seq[15:0]); ics = ocs(ics, 16'h4000);
    ics = ocs(ics, 16'h4011); ics = ocs(ics, s_sip[31:16]); ics = ocs(ics, s_sip[15:0]);
    ics = ocs(ics, s_dip[31:16]); ics = ocs(ics, s_dip[15:0]);
    ics = ~ics;
    s = s_sip[31:16]; s = ocs(s, s_sip[15:0]); s = ocs(s, s_dip[31:16]); s = ocs(s, s_dip[15:0]);
    s = ocs(s, 16'h0011); s = ocs(s, ulen); s = ocs(s, s_sp); s = ocs(s, s_dp); s = ocs(s, ulen);
    s = ocs(s, s_k); s = ocs(s, exp_seq[31:16]); s = ocs(s, exp_seq[15:0]);
    for (int i = 0; i < n; i++) s = ocs(s, slot_w[i]);
    t = ~s;
    if (t == 16'h0000) t = 16'hFFFF;
    ep = 0;
    put(64'(s_dmac), 6); put(64'(s_smac), 6); put(64'h0800, 2);
    put(64'h4500, 2); put(64'(ilen), 2); put(64'(exp_seq[15:0]), 2); put(64'h4000, 2);
    put(64'h4011, 2); put(64'(ics), 2); put(64'(s_sip), 4); put(64'(s_dip), 4);
    put(64'(s_sp), 2); put(64'(s_dp), 2); put(64'(ulen), 2); put(64'(s_k), 2);
    put(64'(exp_seq), 4);
    for (int i = 0; i < n; i++) put(64'(slot_w[i]), 2);
    put(64'(t), 2);
  endtask

  task automatic run_frame(input int n, input int gap_at, input int gap_len, input bit chg);
    int idx, cyc, gap_left, first_bad;
    bit took, done;
    logic [15:0] s;
    s_dmac = cfg_dst_mac; s_smac = cfg_src_mac; s_sip = cfg_src_ip; s_dip = cfg_dst_ip;
    s_sp = cfg_src_port; s_dp = cfg_dst_port; s_k = cfg_csum_const;
    cfg_pay_words = LEN_W'(n);
    cap_n = 0; slot_n = 0; idx = 0; cyc = 0; took = 0; done = 0;
    gap_left = gap_len; low_cnt = 0; sof_ok = 1; eof_ok = 1; hung = 0;
    in_valid = 1'b1; in_data = pw[0];
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin hung = 1; break; end
      if (took) idx++;
      if (out_valid) begin
        cap[cap_n] = out_data;
        if (out_sof != (cap_n == 0)) sof_ok = 0;
        if (out_eof) begin
          done = 1;
          if (cap_n != 48 + 2*n - 1) eof_ok = 0;
        end
        cap_n++;
      end else if (cap_n == 0) begin
        low_cnt++;
      end
      if (chg && cyc == 20) begin
        cfg_dst_mac = ~cfg_dst_mac; cfg_src_ip = ~cfg_src_ip;
        cfg_src_port = cfg_src_port + 16'd7; cfg_csum_const = ~cfg_csum_const;
        cfg_pay_words = LEN_W'(n + 5);
      end
      if (done) break;
      if (in_ready && idx == gap_at && gap_left > 0) begin
        in_valid = 1'b0;
        gap_left--;
        slot_w[slot_n] = FILL; slot_n++;
        took = 0;
      end else begin
        in_valid = (idx < n);
        in_data = pw[idx < n ? idx : 0];
        took = in_valid && in_ready;
        if (took) begin slot_w[slot_n] = pw[idx]; slot_n++; end
      end
    end
    in_valid = 1'b0;
    check(!hung, "R1", "frame completed before watchdog", 32'(cap_n), 32'(48 + 2*n));
    if (hung) return;
    // R10 R1 frame length
    check(cap_n == 48 + 2*n, "R10", "frame byte count", 32'(cap_n), 32'(48 + 2*n));
    check(sof_ok && eof_ok, "R1", "sof/eof placement", {31'd0, sof_ok}, 32'd1);
    check(slot_n == n, "R6", "payload slots taken", 32'(slot_n), 32'(n));
    build_exp(n);
    first_bad = -1;
    for (int i = 0; i < cap_n && i < ep; i++)
      if (cap[i] !== expb[i] && first_bad < 0) first_bad = i;
    check(first_bad < 0, chg ? "R9" : "R1", "frame bytes match model",
          first_bad < 0 ? 32'd0 : {first_bad[23:0], cap[first_bad]},
          first_bad < 0 ? 32'd0 : {first_bad[23:0], expb[first_bad]});
    // R2 IPv4 header verifies
    s = 16'h0000;
    for (int i = 0; i < 10; i++) s = ocs(s, cap16(14 + 2*i));
    check(s == 16'hFFFF, "R2", "ip header sum", 32'(s), 32'hFFFF);
    // R3 UDP datagram verifies with the fixed field
    s = cap16(26); s = ocs(s, cap16(28)); s = ocs(s, cap16(30)); s = ocs(s, cap16(32));
    s = ocs(s, 16'h0011); s = ocs(s, cap16(38));
    for (int i = 34; i + 1 < cap_n; i += 2) s = ocs(s, cap16(i));
    check(s == 16'hFFFF, "R3", "udp sum", 32'(s), 32'hFFFF);
    check(cap16(40) == s_k, "R3", "udp checksum field", 32'(cap16(40)), 32'(s_k));
    check(cap16(cap_n - 2) != 16'h0000, "R4", "trailer nonzero", 32'(cap16(cap_n - 2)), 32'hFFFF);
    check({cap16(42), cap16(44)} == exp_seq, "R5", "packet index",
          {cap16(42), cap16(44)}, exp_seq);
    exp_seq++;
  endtask

  task automatic fill_words(input int n, input int seed);
    for (int i = 0; i < n; i++) pw[i] = 16'(i * 40503 + seed * 257 + 11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] s0;
    int idle_bad;
    cfg_dst_mac = 48'h0A1B2C3D4E5F; cfg_src_mac = 48'h02AABBCCDDEE;
    cfg_src_ip = 32'hC0A80A02; cfg_dst_ip = 32'hC0A80A64;
    cfg_src_port = 16'h1F90; cfg_dst_port = 16'h2710; cfg_csum_const = 16'hBEEF;
    cfg_pay_words = '0; in_data = '0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!out_valid && !out_sof && !out_eof && !in_ready && !underrun, "R12",
          "outputs during reset", {27'd0, out_valid, out_sof, out_eof, in_ready, underrun}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !in_ready && !underrun, "R12", "outputs after reset",
          {29'd0, out_valid, in_ready, underrun}, 32'd0);
    // R7 no frame without data
    idle_bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (out_valid || in_ready) idle_bad++;
    end
    check(idle_bad == 0, "R7", "idle while in_valid low", 32'(idle_bad), 32'd0);

    // sweep of payload lengths and constants (R1 R2 R3 R5 R6 R11)
    for (int n = 1; n <= 12; n++) begin
      fill_words(n, n);
      cfg_csum_const = (n == 3) ? 16'hFFFF : (n == 5) ? 16'h0001 : 16'(n * 4919);
      cfg_src_port = 16'(16'h1F90 + n);
      run_frame(n, -1, 0, 0);
      if (n > 1) check(low_cnt >= 12, "R11", "idle cycles between frames", 32'(low_cnt), 32'd12);
    end
    check(!underrun, "R8", "flag clear without underrun", {31'd0, underrun}, 32'd0);

    // R4 force a zero required trailer
    begin
      int n;
      logic [15:0] ulen;
      n = 6;
      fill_words(n, 99);
      cfg_csum_const = 16'h3C3C;
      ulen = 16'(14 + 2*n);
      s0 = cfg_src_ip[31:16]; s0 = ocs(s0, cfg_src_ip[15:0]); s0 = ocs(s0, cfg_dst_ip[31:16]);
      s0 = ocs(s0, cfg_dst_ip[15:0]); s0 = ocs(s0, 16'h0011); s0 = ocs(s0, ulen);
      s0 = ocs(s0, cfg_src_port); s0 = ocs(s0, cfg_dst_port); s0 = ocs(s0, ulen);
      s0 = ocs(s0, cfg_csum_const); s0 = ocs(s0, exp_seq[31:16]); s0 = ocs(s0, exp_seq[15:0]);
      for (int i = 0; i < n - 1; i++) s0 = ocs(s0, pw[i]);
      pw[n-1] = ~s0;
      run_frame(n, -1, 0, 0);
      check(cap16(cap_n - 2) == 16'hFFFF, "R4", "zero trailer sent as FFFF",
            32'(cap16(cap_n - 2)), 32'hFFFF);
    end

    // R9 configuration changed mid-frame
    fill_words(20, 7);
    run_frame(20, -1, 0, 1);
    // R9 the new configuration applies to the next frame
    fill_words(9, 8);
    run_frame(9, -1, 0, 0);

    // R8 mid-frame underrun
    fill_words(16, 3);
    run_frame(16, 5, 3, 0);
    check(underrun, "R8", "flag set after underrun", {31'd0, underrun}, 32'd1);
    check(slot_w[5] == FILL && slot_w[6] == FILL && slot_w[7] == FILL && slot_w[8] == pw[5],
          "R8", "fill words in skipped slots", 32'(slot_w[5]), 32'(FILL));
    fill_words(4, 4);
    run_frame(4, -1, 0, 0);
    check(underrun, "R8", "flag still set on next frame", {31'd0, underrun}, 32'd1);

    // R10 jumbo frame
    fill_words(1200, 5);
    cfg_csum_const = 16'h7E57;
    run_frame(1200, -1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule